// File: doc/BRIEF.md
# Phase-Programmable Clock Channel Divider Bank

This block is a bank of identical clock channel dividers, all driven by one common input clock. Each channel divides that clock by a 10-bit ratio and produces an exact 50% duty cycle for every ratio, odd ratios included. To do this it runs at half-period resolution: the low half is produced by a register clocked on the falling edge. Each channel can delay its first output edge by a number of half input periods, invert its output, be powered down, or be excluded from synchronisation.

A shared synchronisation controller keeps every participating channel static at its idle level while the output PLL reports no lock. When lock arrives, or when a force-release input is set, the controller lets all channels go on the same input edge, so their outputs start aligned. After that, each channel's phase setting shifts only its first period. A manual sync request restarts the participating channels when the request is cleared.

Top module: `clkdiv_phase_bank`

## Requirements
- R1: While `rst_ni` is low, every bit of `clk_o` is 0.
- R2: A running channel with ratio D repeats a period of 2·D input half-periods: D half-periods high, then D half-periods low. A ratio of 0 acts as 1.
- R3: After release, a channel stays low for P input half-periods, where P is its 6-bit phase value. Its first high half-period then starts. P=0 gives no offset and P=63 gives 31.5 input periods.
- R4: The phase offset affects only the first output period. Every later period follows R2 exactly.
- R5: When a channel's invert bit is 1, its output is the complement of the non-inverted waveform, including the idle level.
- R6: A channel whose power-down bit is 1 drives 0, whatever its invert bit, and restarts from its phase preset when the bit is cleared.
- R7: While both `pll_locked_i` and `force_release_i` are 0, every channel that neither ignores sync nor is powered down holds its idle level: 0, or 1 when inverted.
- R8: If release is first seen at input clock edge E0, half-period h of every participating channel appears at h/2 cycles after edge E1 (the edge after E0). Even h falls in the high phase of the clock and odd h in the low phase. All channels are therefore aligned.
- R9: `force_release_i`=1 releases the channels exactly as lock does, while `pll_locked_i` is 0.
- R10: A 1-to-0 transition of `sync_req_i` seen at edge F0 makes participating channels show their idle level for the clock cycle after edge F1. They then restart with half-period 0 at edge F2. Raising `sync_req_i` or holding it high has no effect.
- R11: A channel whose ignore-sync bit is 1 keeps running through a hold (R7) and through a manual sync (R10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common divider input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pll_locked_i | input | 1 | Output PLL lock indication |
| force_release_i | input | 1 | Release channels regardless of lock |
| sync_req_i | input | 1 | Manual sync request; acts on its falling transition |
| ratio_i | input | NUM_CH*RATIO_W | Per-channel divide ratio, channel i at bits [i*RATIO_W +: RATIO_W] |
| phase_i | input | NUM_CH*PHASE_W | Per-channel first-edge delay in half input periods |
| invert_i | input | NUM_CH | Per-channel output inversion |
| ignore_sync_i | input | NUM_CH | Per-channel exclusion from hold and manual sync |
| pwrdn_i | input | NUM_CH | Per-channel power-down |
| clk_o | output | NUM_CH | Divided channel clocks |

## Verification
Each channel's state is a remaining-delay counter and a position inside the output period. A fault in either one misplaces an output edge within the current output period. A wrong delay count moves the first edge after release by a whole number of half input periods. A wrong wrap of the position changes every period that follows. A channel that misses a hold or restart stays misaligned from its neighbours from the first half-period after release. Sampling every half-period against a waveform computed from ratio and phase therefore exposes such faults within one output period.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int unsigned CDB_NUM_CH      = 6;
  localparam int unsigned CDB_RATIO_W     = 10;
  localparam int unsigned CDB_PHASE_W     = 6;
  localparam int unsigned CDB_SYNC_STAGES = 2;

  typedef struct packed {
    logic run;      // channels may advance
    logic restart;  // one-cycle preset from a manual sync
  } cdb_ctrl_t;
endpackage

// File: rtl/cdb_sync_ctrl.sv
module cdb_sync_ctrl
  import cdb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = CDB_SYNC_STAGES
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pll_locked_i,
  input  logic      force_release_i,
  input  logic      sync_req_i,
  output logic      rst_int_no,
  output cdb_ctrl_t ctrl_o
);
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   sreq_q;
  cdb_ctrl_t              ctrl_q, ctrl_d;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_no = rst_pipe_q[SYNC_STAGES-1];

  always_comb begin
    ctrl_d.run     = pll_locked_i | force_release_i;
    ctrl_d.restart = sreq_q & ~sync_req_i;
  end

  always_ff @(posedge clk_i or negedge rst_int_no) begin
    if (!rst_int_no) begin
      ctrl_q <= '0;
      sreq_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      sreq_q <= sync_req_i;
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/cdb_channel.sv
module cdb_channel #(
  parameter int unsigned RATIO_W = 10,
  parameter int unsigned PHASE_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hold_i,
  input  logic               pwrdn_i,
  input  logic               invert_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               lvl_a_o,
  output logic               lvl_b_o
);
  localparam int unsigned POS_W = RATIO_W + 1;

  typedef struct packed {
    logic [PHASE_W-1:0] wait_cnt;
    logic [POS_W-1:0]   pos;
  } chan_st_t;

  chan_st_t         st_q, st_d, st_h1, st_h2, st_preset;
  logic [POS_W-1:0] eff, per;

  // advance by one input half-period
  function automatic chan_st_t half_step(chan_st_t s, logic [POS_W-1:0] p);
    chan_st_t r = s;
    if (s.wait_cnt != '0)        r.wait_cnt = s.wait_cnt - 1'b1;
    else if (s.pos + 1'b1 >= p)  r.pos = '0;
    else                         r.pos = s.pos + 1'b1;
    return r;
  endfunction

  function automatic logic half_level(chan_st_t s, logic [POS_W-1:0] e);
    return (s.wait_cnt == '0) && (s.pos < e);
  endfunction

  always_comb begin
    eff       = (ratio_i == '0) ? POS_W'(1) : POS_W'(ratio_i);
    per       = {eff[POS_W-2:0], 1'b0};
    st_h1     = half_step(st_q, per);
    st_h2     = half_step(st_h1, per);
    st_preset = '{wait_cnt: phase_i, pos: '0};
    if (pwrdn_i) begin
      st_d    = st_preset;
      lvl_a_o = 1'b0;
      lvl_b_o = 1'b0;
    end else if (hold_i) begin
      st_d    = st_preset;
      lvl_a_o = invert_i;
      lvl_b_o = invert_i;
    end else begin
      st_d    = st_h2;
      lvl_a_o = half_level(st_q, eff) ^ invert_i;
      lvl_b_o = half_level(st_h1, eff) ^ invert_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/cdb_out_cell.sv
module cdb_out_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_a_i,
  input  logic lvl_b_i,
  output logic clk_o
);
  logic rise_q, rise_d, fall_q, fall_d, b_q;

  // rise_q ^ fall_q shows lvl_a in the high phase and lvl_b in the low phase
  always_comb begin
    rise_d = lvl_a_i ^ fall_q;
    fall_d = b_q ^ rise_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= 1'b0;
      b_q    <= 1'b0;
    end else begin
      rise_q <= rise_d;
      b_q    <= lvl_b_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= 1'b0;
    else         fall_q <= fall_d;
  end

  assign clk_o = rise_q ^ fall_q;
endmodule

// File: rtl/clkdiv_phase_bank.sv
module clkdiv_phase_bank
  import cdb_pkg::*;
#(
  parameter int unsigned NUM_CH  = CDB_NUM_CH,
  parameter int unsigned RATIO_W = CDB_RATIO_W,
  parameter int unsigned PHASE_W = CDB_PHASE_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      pll_locked_i,
  input  logic                      force_release_i,
  input  logic                      sync_req_i,
  input  logic [NUM_CH*RATIO_W-1:0] ratio_i,
  input  logic [NUM_CH*PHASE_W-1:0] phase_i,
  input  logic [NUM_CH-1:0]         invert_i,
  input  logic [NUM_CH-1:0]         ignore_sync_i,
  input  logic [NUM_CH-1:0]         pwrdn_i,
  output logic [NUM_CH-1:0]         clk_o
);
  logic      rst_int_n;
  cdb_ctrl_t ctrl;

  cdb_sync_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pll_locked_i   (pll_locked_i),
    .force_release_i(force_release_i),
    .sync_req_i     (sync_req_i),
    .rst_int_no     (rst_int_n),
    .ctrl_o         (ctrl)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hold, lvl_a, lvl_b;
    assign hold = ~ignore_sync_i[i] & (~ctrl.run | ctrl.restart);

    cdb_channel #(.RATIO_W(RATIO_W), .PHASE_W(PHASE_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_int_n),
      .hold_i  (hold),
      .pwrdn_i (pwrdn_i[i]),
      .invert_i(invert_i[i]),
      .ratio_i (ratio_i[i*RATIO_W +: RATIO_W]),
      .phase_i (phase_i[i*PHASE_W +: PHASE_W]),
      .lvl_a_o (lvl_a),
      .lvl_b_o (lvl_b)
    );

    cdb_out_cell u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_int_n),
      .lvl_a_i(lvl_a),
      .lvl_b_i(lvl_b),
      .clk_o  (clk_o[i])
    );
  end
endmodule

// File: rtl/clkdiv_phase_bank_chk.sv
module clkdiv_phase_bank_chk #(
  parameter int unsigned NUM_CH  = 6,
  parameter int unsigned RATIO_W = 10,
  parameter int unsigned PHASE_W = 6
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      pll_locked_i,
  input logic                      force_release_i,
  input logic                      sync_req_i,
  input logic [NUM_CH*RATIO_W-1:0] ratio_i,
  input logic [NUM_CH*PHASE_W-1:0] phase_i,
  input logic [NUM_CH-1:0]         invert_i,
  input logic [NUM_CH-1:0]         ignore_sync_i,
  input logic [NUM_CH-1:0]         pwrdn_i,
  input logic [NUM_CH-1:0]         clk_o
);
  logic [3:0] since_rst;
  logic       settled, held;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_rst <= '0;
    else if (since_rst != 4'hf)  since_rst <= since_rst + 1'b1;
  end
  assign settled = (since_rst >= 4'd8);
  assign held    = ~(pll_locked_i | force_release_i);

  // R1
  a_r1_reset_low: assert property (@(posedge clk_i) !rst_ni |-> clk_o == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    // R6
    a_r6_pwrdn_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settled && $past(pwrdn_i[i])) |-> (clk_o[i] == 1'b0));

    // R7
    a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settled && held && $past(held) && $past(held, 2)
       && !ignore_sync_i[i] && !$past(ignore_sync_i[i])
       && !pwrdn_i[i] && !$past(pwrdn_i[i])
       && (invert_i[i] == $past(invert_i[i])))
      |-> (clk_o[i] == invert_i[i]));

    // R10
    a_r10_sync_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settled && $past(sync_req_i, 3) && !$past(sync_req_i, 2)
       && !ignore_sync_i[i] && !$past(ignore_sync_i[i])
       && !pwrdn_i[i] && !$past(pwrdn_i[i])
       && (invert_i[i] == $past(invert_i[i])))
      |-> (clk_o[i] == invert_i[i]));
  end
endmodule

bind clkdiv_phase_bank clkdiv_phase_bank_chk #(
  .NUM_CH (NUM_CH),
  .RATIO_W(RATIO_W),
  .PHASE_W(PHASE_W)
) u_chk (.*);

// File: tb/clkdiv_phase_bank_tb.sv
`timescale 1ns/1ps
module clkdiv_phase_bank_tb;
  localparam int NCH = 6;
  localparam int RW  = 10;
  localparam int PW  = 6;
  localparam int NV  = 8;
  // fields: [17] force, [16] invert, [15:10] phase, [9:0] ratio
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b0, 6'd0,  10'd1},
    {1'b0, 1'b0, 6'd1,  10'd2},
    {1'b0, 1'b1, 6'd0,  10'd3},
    {1'b0, 1'b0, 6'd2,  10'd0},
    {1'b1, 1'b0, 6'd7,  10'd5},
    {1'b0, 1'b1, 6'd63, 10'd4},
    {1'b0, 1'b0, 6'd5,  10'd1023},
    {1'b1, 1'b1, 6'd9,  10'd7}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n, lock, frc, sreq;
  logic [RW-1:0]  rat [NCH];
  logic [PW-1:0]  ph  [NCH];
  logic [NCH-1:0] inv, ign, pd, clk_out;
  logic [NCH*RW-1:0] ratio_bus;
  logic [NCH*PW-1:0] phase_bus;

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      ratio_bus[k*RW +: RW] = rat[k];
      phase_bus[k*PW +: PW] = ph[k];
    end
  end

  clkdiv_phase_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pll_locked_i(lock), .force_release_i(frc),
    .sync_req_i(sreq), .ratio_i(ratio_bus), .phase_i(phase_bus),
    .invert_i(inv), .ignore_sync_i(ign), .pwrdn_i(pd), .clk_o(clk_out)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  task automatic chk(input string tag, input int ch, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s ch%0d: actual %b expected %b at %0t", tag, ch, act, exp, $time);
    end
  endtask

  function automatic logic model(input int d, input int p, input int h, input logic iv);
    int de = (d == 0) ? 1 : d;
    if (h < p) return iv;
    return ((((h - p) % (2 * de)) < de) ? 1'b1 : 1'b0) ^ iv;
  endfunction

  // ch4 always powered down & inverted (R6); ch5 ignores sync, ratio 1 (R11)
  task automatic side_checks(input int h);
    chk("R6", 4, clk_out[4], 1'b0);
    chk("R11", 5, clk_out[5], (h % 2 == 0) ? 1'b1 : 1'b0);
  endtask

  initial begin
    rst_n = 0; lock = 0; frc = 0; sreq = 0;
    for (int k = 0; k < NCH; k++) begin rat[k] = 10'd1; ph[k] = '0; end
    inv = 6'b010000; ign = 6'b100000; pd = 6'b010000;
    repeat (3) @(posedge clk);
    #1;
    for (int k = 0; k < NCH; k++) chk("R1", k, clk_out[k], 1'b0);
    @(negedge clk) rst_n = 1;
    repeat (8) @(posedge clk);
    #1;
    for (int k = 0; k < 4; k++) chk("R7", k, clk_out[k], 1'b0);
    side_checks(0);
    @(negedge clk); #1;
    side_checks(1);

    // table walk: ratio, phase, invert, release source
    for (int v = 0; v < NV; v++) begin
      int d0, p0, dmax, nh;
      logic iv0, use_f;
      d0 = int'(VEC[v][9:0]); p0 = int'(VEC[v][15:10]);
      iv0 = VEC[v][16]; use_f = VEC[v][17];
      @(negedge clk);
      lock = 0; frc = 0;
      dmax = 1;
      for (int k = 0; k < 4; k++) begin
        rat[k] = RW'(d0 ^ k); ph[k] = PW'(p0 ^ k); inv[k] = iv0 ^ k[0];
        if ((d0 ^ k) > dmax) dmax = d0 ^ k;
      end
      repeat (4) @(posedge clk);
      #1;
      for (int k = 0; k < 4; k++) chk("R7 hold idle", k, clk_out[k], inv[k]);
      side_checks(0);
      @(negedge clk); #1;
      for (int k = 0; k < 4; k++) chk("R7 hold idle R5", k, clk_out[k], inv[k]);
      side_checks(1);
      @(negedge clk);
      if (use_f) frc = 1; else lock = 1;
      @(posedge clk); @(posedge clk);
      nh = 130 + 4 * dmax;
      for (int c = 0; c < nh / 2; c++) begin
        #1;
        for (int k = 0; k < 4; k++)
          chk(use_f ? "R9 R2 R3 R4 R8" : "R2 R3 R4 R5 R8", k, clk_out[k],
              model(int'(rat[k]), int'(ph[k]), 2 * c, inv[k]));
        side_checks(2 * c);
        @(negedge clk); #1;
        for (int k = 0; k < 4; k++)
          chk(use_f ? "R9 R2 R3 R4 R8" : "R2 R3 R4 R5 R8", k, clk_out[k],
              model(int'(rat[k]), int'(ph[k]), 2 * c + 1, inv[k]));
        side_checks(2 * c + 1);
        @(posedge clk);
      end
    end

    // manual sync: rise/high has no effect, fall restarts (R10)
    @(negedge clk);
    lock = 0; frc = 0;
    rat[0] = 10'd1; ph[0] = 6'd3; inv[0] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) lock = 1;
    repeat (6) @(posedge clk);
    @(negedge clk) sreq = 1;
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); #1;
      chk("R10 high no effect", 0, clk_out[0], 1'b0);
      side_checks(0);
      @(negedge clk); #1;
      chk("R10 high no effect", 0, clk_out[0], 1'b1);
      side_checks(1);
    end
    @(negedge clk) sreq = 0;
    @(posedge clk); @(posedge clk);
    #1;
    chk("R10 idle", 0, clk_out[0], 1'b0);
    side_checks(0);
    @(negedge clk); #1;
    chk("R10 idle", 0, clk_out[0], 1'b0);
    side_checks(1);
    @(posedge clk);
    for (int c = 0; c < 8; c++) begin
      #1;
      chk("R10 restart R3", 0, clk_out[0], model(1, 3, 2 * c, 1'b0));
      side_checks(2 * c);
      @(negedge clk); #1;
      chk("R10 restart R3", 0, clk_out[0], model(1, 3, 2 * c + 1, 1'b0));
      side_checks(2 * c + 1);
      @(posedge clk);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule